// File: doc/BRIEF.md
# Bridge Interrupt Status Aggregator

This block gathers the interrupt sources of a bus bridge into two groups and raises one interrupt output for each group. The first group holds up to fifteen miscellaneous error and event flags. Each flag is captured from a one-cycle pulse and stays set until software clears it by writing a one. The second group mirrors the four legacy interrupt wires (INTA to INTD). These wires are level-sensitive, so their status simply follows the wires and software never clears it.

Each group has an enable mask. A mask bit of one lets the matching status bit reach the group's interrupt output. Both outputs are registered. Software reaches the four registers over a simple register bus. Writes take effect at a clock edge. Read data is combinational from the address.

Top module: `bridge_irq_agg`

## Requirements
- R1: During and after reset, both status registers and both mask registers read zero, and both interrupt outputs are low.
- R2: A pulse on `misc_evt_i` at a defined bit position sets that bit of the miscellaneous status register (offset 0x400). The bit stays set after the pulse ends.
- R3: The defined miscellaneous positions are bits 0, 1, 4, 5, 6, 7, 16, 17, 18, 20, 22, 23, 24, 25 and 26 (value 0x07D700F3). Every other bit of the status and mask registers reads zero and ignores events and writes.
- R4: Writing to offset 0x400 clears each status bit written as one and leaves each bit written as zero unchanged.
- R5: An event on a bit in the same cycle as a one-write to that bit leaves the bit set.
- R6: The miscellaneous mask sits at offset 0x404, and a one enables the source. `misc_irq_o` is the OR of status AND mask, registered, so it rises one clock after the status bit it reflects.
- R7: The legacy status at offset 0x420 holds INTA to INTD in bits 0 to 3. It follows `int_lines_i` one clock late, and writes to it have no effect.
- R8: The legacy mask sits at offset 0x424 in bits 0 to 3, and a one enables the line. `intx_irq_o` is the OR of legacy status AND mask, registered once.
- R9: A read of any other offset returns zero, and a write to any other offset changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| misc_evt_i | input | 32 | Miscellaneous event pulses, one per bit position |
| int_lines_i | input | 4 | Legacy interrupt levels, INTA in bit 0 |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 12 | Register byte offset |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for `reg_addr_i` |
| misc_irq_o | output | 1 | Miscellaneous interrupt request |
| intx_irq_o | output | 1 | Legacy interrupt request |

## Verification
A lost or spurious sticky bit shows at the next read of offset 0x400. If the bit is enabled, it also shows one clock later as a wrong level on `misc_irq_o`. A clear-versus-set race that resolves the wrong way drops an event with no trace, so the bench drives both in the same cycle and reads the result on the next clock. A legacy status that latches instead of following the wire shows as `intx_irq_o` staying high one clock after the wire drops.

// File: rtl/bridge_irq_agg.sv
module bridge_irq_agg #(
  parameter int AW = 12,
  parameter int DW = 32,
  parameter int NLEG = 4,
  parameter logic [DW-1:0] MISC_VALID = 32'h07D7_00F3,
  parameter logic [AW-1:0] A_MSTAT = 12'h400,
  parameter logic [AW-1:0] A_MMASK = 12'h404,
  parameter logic [AW-1:0] A_LSTAT = 12'h420,
  parameter logic [AW-1:0] A_LMASK = 12'h424
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [DW-1:0]   misc_evt_i,
  input  logic [NLEG-1:0] int_lines_i,
  input  logic            reg_wr_i,
  input  logic [AW-1:0]   reg_addr_i,
  input  logic [DW-1:0]   reg_wdata_i,
  output logic [DW-1:0]   reg_rdata_o,
  output logic            misc_irq_o,
  output logic            intx_irq_o
);

  logic [DW-1:0]   misc_stat, misc_mask;
  logic [NLEG-1:0] leg_stat, leg_mask;

  wire wr_mstat = reg_wr_i && (reg_addr_i == A_MSTAT);
  wire wr_mmask = reg_wr_i && (reg_addr_i == A_MMASK);
  wire wr_lmask = reg_wr_i && (reg_addr_i == A_LMASK);

  wire [DW-1:0] clr_bits = wr_mstat ? reg_wdata_i : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      misc_stat  <= '0;
      misc_mask  <= '0;
      leg_stat   <= '0;
      leg_mask   <= '0;
      misc_irq_o <= 1'b0;
      intx_irq_o <= 1'b0;
    end else begin
      misc_stat  <= ((misc_stat & ~clr_bits) | misc_evt_i) & MISC_VALID;
      leg_stat   <= int_lines_i;
      if (wr_mmask) misc_mask <= reg_wdata_i & MISC_VALID;
      if (wr_lmask) leg_mask <= reg_wdata_i[NLEG-1:0];
      misc_irq_o <= |(misc_stat & misc_mask);
      intx_irq_o <= |(leg_stat & leg_mask);
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    case (reg_addr_i)
      A_MSTAT: reg_rdata_o = misc_stat;
      A_MMASK: reg_rdata_o = misc_mask;
      A_LSTAT: reg_rdata_o[NLEG-1:0] = leg_stat;
      A_LMASK: reg_rdata_o[NLEG-1:0] = leg_mask;
      default: reg_rdata_o = '0;
    endcase
  end

endmodule

// File: rtl/bridge_irq_agg_chk.sv
module bridge_irq_agg_chk #(
  parameter int AW = 12,
  parameter int DW = 32,
  parameter int NLEG = 4,
  parameter logic [DW-1:0] MISC_VALID = 32'h07D7_00F3,
  parameter logic [AW-1:0] A_MSTAT = 12'h400
) (
  input logic            clk,
  input logic            rst_n,
  input logic [DW-1:0]   misc_evt_i,
  input logic [NLEG-1:0] int_lines_i,
  input logic            reg_wr_i,
  input logic [AW-1:0]   reg_addr_i,
  input logic [DW-1:0]   reg_wdata_i,
  input logic [DW-1:0]   reg_rdata_o,
  input logic            misc_irq_o,
  input logic            intx_irq_o,
  input logic [DW-1:0]   misc_stat,
  input logic [DW-1:0]   misc_mask,
  input logic [NLEG-1:0] leg_stat,
  input logic [NLEG-1:0] leg_mask
);

  assert_undef_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr_i == A_MSTAT) |-> ((reg_rdata_o & ~MISC_VALID) == '0));

  assert_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr_i && reg_addr_i == A_MSTAT) |=> (($past(misc_stat) & ~misc_stat) == '0));

  assert_w1c_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_i && reg_addr_i == A_MSTAT && misc_evt_i == '0) |=>
      ((misc_stat & $past(reg_wdata_i)) == '0));

  assert_set_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((misc_evt_i & MISC_VALID) != '0) |=>
      ((misc_stat & $past(misc_evt_i & MISC_VALID)) == $past(misc_evt_i & MISC_VALID)));

  assert_misc_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    misc_irq_o |-> ($past(misc_mask) != '0));

  assert_leg_follow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (leg_stat == $past(int_lines_i)));

  assert_intx_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
    intx_irq_o |-> ($past(leg_mask) != '0));

endmodule

bind bridge_irq_agg bridge_irq_agg_chk #(
  .AW(AW), .DW(DW), .NLEG(NLEG), .MISC_VALID(MISC_VALID), .A_MSTAT(A_MSTAT)
) chk_i (
  .clk(clk), .rst_n(rst_n), .misc_evt_i(misc_evt_i), .int_lines_i(int_lines_i),
  .reg_wr_i(reg_wr_i), .reg_addr_i(reg_addr_i), .reg_wdata_i(reg_wdata_i),
  .reg_rdata_o(reg_rdata_o), .misc_irq_o(misc_irq_o), .intx_irq_o(intx_irq_o),
  .misc_stat(misc_stat), .misc_mask(misc_mask), .leg_stat(leg_stat), .leg_mask(leg_mask)
);

// File: tb/bridge_irq_agg_tb_top.sv
`timescale 1ns/1ps
module bridge_irq_agg_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] misc_evt_i = '0;
  logic [3:0]  int_lines_i = '0;
  logic        reg_wr_i = 1'b0;
  logic [11:0] reg_addr_i = '0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic        misc_irq_o, intx_irq_o;

  int checks = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  bridge_irq_agg dut_i (
    .clk(clk), .rst_n(rst_n), .misc_evt_i(misc_evt_i), .int_lines_i(int_lines_i),
    .reg_wr_i(reg_wr_i), .reg_addr_i(reg_addr_i), .reg_wdata_i(reg_wdata_i),
    .reg_rdata_o(reg_rdata_o), .misc_irq_o(misc_irq_o), .intx_irq_o(intx_irq_o)
  );

  typedef struct packed {
    logic [31:0] evt;
    logic [3:0]  lines;
    logic        wr;
    logic [11:0] addr;
    logic [31:0] wdata;
    logic [31:0] exp_ms;
    logic [3:0]  exp_ls;
    logic        exp_mi;
    logic        exp_li;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{32'h0,          4'h0, 1'b1, 12'h404, 32'hFFFF_FFFF, 32'h0,          4'h0, 1'b0, 1'b0},
    '{32'h1,          4'h0, 1'b0, 12'h000, 32'h0,         32'h1,          4'h0, 1'b1, 1'b0},
    '{32'hF800_0008,  4'h0, 1'b0, 12'h000, 32'h0,         32'h1,          4'h0, 1'b1, 1'b0},
    '{32'h0,          4'h0, 1'b1, 12'h400, 32'h0,         32'h1,          4'h0, 1'b1, 1'b0},
    '{32'h07D7_00F2,  4'h0, 1'b0, 12'h000, 32'h0,         32'h07D7_00F3,  4'h0, 1'b1, 1'b0},
    '{32'h0,          4'h0, 1'b1, 12'h400, 32'h07D7_00F3, 32'h0,          4'h0, 1'b0, 1'b0},
    '{32'h0,          4'h0, 1'b1, 12'h404, 32'h0000_0010, 32'h0,          4'h0, 1'b0, 1'b0},
    '{32'h20,         4'h0, 1'b0, 12'h000, 32'h0,         32'h20,         4'h0, 1'b0, 1'b0},
    '{32'h10,         4'h0, 1'b0, 12'h000, 32'h0,         32'h30,         4'h0, 1'b1, 1'b0},
    '{32'h0,          4'h5, 1'b0, 12'h000, 32'h0,         32'h30,         4'h5, 1'b1, 1'b0},
    '{32'h0,          4'h5, 1'b1, 12'h424, 32'hF,         32'h30,         4'h5, 1'b1, 1'b1},
    '{32'h0,          4'h0, 1'b1, 12'h420, 32'hF,         32'h30,         4'h0, 1'b1, 1'b0},
    '{32'h10,         4'h0, 1'b1, 12'h400, 32'h30,        32'h10,         4'h0, 1'b1, 1'b0}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    reg_addr_i = a;
    #0.5;
    d = reg_rdata_o;
    reg_addr_i = '0;
  endtask

  task automatic wr_cycle(input logic [11:0] a, input logic [31:0] d);
    reg_wr_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk);
    reg_wr_i = 1'b0; reg_addr_i = '0; reg_wdata_i = '0;
  endtask

  initial begin : watchdog
    #(5.0 * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin : main
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rd(12'h400, d); check("R1 misc status in reset", d, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    rd(12'h400, d); check("R1 misc status", d, 32'h0);
    rd(12'h404, d); check("R1 misc mask", d, 32'h0);
    rd(12'h420, d); check("R1 legacy status", d, 32'h0);
    rd(12'h424, d); check("R1 legacy mask", d, 32'h0);
    check("R1 misc irq", {31'b0, misc_irq_o}, 32'h0);
    check("R1 intx irq", {31'b0, intx_irq_o}, 32'h0);

    // Table walk: R2 sticky, R3 undefined, R4 W1C, R5 set wins, R6/R7/R8 irq paths
    for (int i = 0; i < NV; i++) begin
      misc_evt_i = VECS[i].evt;
      int_lines_i = VECS[i].lines;
      reg_wr_i = VECS[i].wr;
      reg_addr_i = VECS[i].addr;
      reg_wdata_i = VECS[i].wdata;
      @(negedge clk);
      misc_evt_i = '0; reg_wr_i = 1'b0; reg_addr_i = '0; reg_wdata_i = '0;
      @(negedge clk);
      rd(12'h400, d); check($sformatf("R2/R4/R5 vec %0d misc status", i), d, VECS[i].exp_ms);
      rd(12'h420, d); check($sformatf("R7 vec %0d legacy status", i), d, {28'b0, VECS[i].exp_ls});
      check($sformatf("R6 vec %0d misc irq", i), {31'b0, misc_irq_o}, {31'b0, VECS[i].exp_mi});
      check($sformatf("R8 vec %0d intx irq", i), {31'b0, intx_irq_o}, {31'b0, VECS[i].exp_li});
    end

    // R3: undefined mask bits ignore writes
    wr_cycle(12'h404, 32'hFFFF_FFFF);
    rd(12'h404, d); check("R3 mask undefined bits", d, 32'h07D7_00F3);

    // R6: misc irq rises exactly one clock after status
    wr_cycle(12'h400, 32'hFFFF_FFFF);
    @(negedge clk);
    misc_evt_i = 32'h0400_0000;
    @(negedge clk);
    misc_evt_i = '0;
    rd(12'h400, d); check("R6 status set first", d, 32'h0400_0000);
    check("R6 irq not yet", {31'b0, misc_irq_o}, 32'h0);
    @(negedge clk);
    check("R6 irq one clock later", {31'b0, misc_irq_o}, 32'h1);

    // R7: legacy status ignores writes
    int_lines_i = 4'hA;
    @(negedge clk);
    wr_cycle(12'h420, 32'h0);
    rd(12'h420, d); check("R7 legacy write ignored", d, 32'hA);
    // R8: legacy mask upper bits
    rd(12'h424, d); check("R8 legacy mask bits 0-3", d, 32'hF);
    int_lines_i = 4'h0;

    // R9: other offsets
    wr_cycle(12'h408, 32'hFFFF_FFFF);
    rd(12'h408, d); check("R9 unmapped read", d, 32'h0);
    rd(12'h404, d); check("R9 mask untouched", d, 32'h07D7_00F3);
    rd(12'h400, d); check("R9 status untouched", d, 32'h0400_0000);

    // R1: reset mid-run
    int_lines_i = 4'hF;
    @(negedge clk);
    rst_n = 1'b0;
    #0.5;
    rd(12'h400, d); check("R1 mid-run status", d, 32'h0);
    rd(12'h404, d); check("R1 mid-run mask", d, 32'h0);
    rd(12'h420, d); check("R1 mid-run legacy", d, 32'h0);
    check("R1 mid-run misc irq", {31'b0, misc_irq_o}, 32'h0);
    check("R1 mid-run intx irq", {31'b0, intx_irq_o}, 32'h0);
    @(negedge clk);
    int_lines_i = 4'h0;
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule